// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block produces the serial clock level for an I2C master controller. A down counter loads a 7-bit divisor, drops by one on each phase tick and, when it has reached zero, reloads on the next tick while the SCL drive level flips. One SCL period therefore takes two rollovers. Each half period lasts divisor+1 ticks. The tick enable is pulsed twice per instruction cycle, so the counter runs at twice the instruction rate.

Counting begins when software writes the transmit buffer. It ends when the master sequencer reports that the byte and its acknowledge bit are done. At that point the SCL drive level stays wherever it last was. A single-cycle rollover pulse lets the master sequencer step its bit state. After the block releases SCL high, it reads the sampled bus level. While another device holds the line low, the counter stays at its reload value, so a stretched or slowly rising clock lengthens the period instead of shortening the high phase.

Top module: `scl_rate_gen`

## Requirements
- R1: The reload value is bits [6:0] of `divisor_i`. Bit 7 has no effect on timing.
- R2: A one-cycle pulse on `buf_wr_i` loads the counter and starts it. The first SCL change after a start, from the idle high level, is high to low.
- R3: While the counter is stopped, `tick_i` pulses neither change `scl_drive_o` nor raise `roll_o`.
- R4: The counter moves only on clock edges where `tick_i` is 1. Each half period of SCL spans reload+1 ticks, however far apart the ticks are.
- R5: On every rollover the counter reloads from the divisor value present at that edge. A divisor change that arrives in mid half period first takes effect in the next half period. A full SCL period is two rollovers.
- R6: A reload value of 0 gives one tick per half period.
- R7: While `scl_drive_o` is 1 and `scl_in_i` reads 0 (clock stretch), the counter is held at its reload value on every tick. The high phase then lasts reload+1 ticks counted from the tick after the line reads high.
- R8: `roll_o` is high for exactly the one cycle that follows each edge where `scl_drive_o` changes, and at no other time.
- R9: A `seq_done_i` pulse stops counting and freezes `scl_drive_o` at its current level, low or high. A later `buf_wr_i` restarts from that level.
- R10: Synchronous active-high `rst` stops the counter, sets `scl_drive_o` to 1 (released) and clears `roll_o`.
- R11: When `buf_wr_i` and `seq_done_i` are high on the same edge, the start wins and a full half period of reload+1 ticks follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Phase tick enable, two per instruction cycle |
| divisor_i | input | 8 | Divisor register; bits [6:0] are the reload value |
| buf_wr_i | input | 1 | Transmit buffer write strobe; starts counting |
| seq_done_i | input | 1 | Byte-plus-acknowledge finished; stops counting |
| scl_in_i | input | 1 | Sampled SCL bus level, used to detect stretching |
| scl_drive_o | output | 1 | SCL drive level: 1 releases the line, 0 pulls it low |
| roll_o | output | 1 | One-cycle pulse after each rollover |

## Verification
The half-period length is measured across a table of divisors and tick spacings:
- Tick every cycle versus every second cycle separates a counter that honours the tick enable from one that runs on the raw clock.
- A divisor with bit 7 set exposes a counter that uses too many divisor bits.
- Reload values of 0 and 127 probe both ends of the counter range.

Directed runs cover these cases:
- Change the divisor in mid half period, to show the reload happens only at rollover.
- Hold SCL low after release, to show the high phase waits for the bus.
- Stop at both SCL levels, to show the level is frozen rather than reset.
- Start and stop on the same edge, to show which one has priority.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    typedef enum logic {
        BRG_HALT = 1'b0,
        BRG_RUN  = 1'b1
    } brg_mode_e;

    typedef struct packed {
        logic level;
        logic roll;
    } scl_state_t;

    localparam logic SCL_RELEASED = 1'b1;

endpackage

// File: rtl/scl_stretch_detect.sv
module scl_stretch_detect (
    input  logic scl_drive_i,
    input  logic scl_in_i,
    output logic hold_o
);

    // Released but the bus still reads low: another device holds the clock.
    always_comb begin
        hold_o = scl_drive_i & ~scl_in_i;
    end

endmodule

// File: rtl/scl_brg_counter.sv
module scl_brg_counter
    import scl_div_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             hold_i,
    output logic             roll_evt_o,
    output logic             running_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        brg_mode_e        mode;
        logic [CNT_W-1:0] cnt;
    } brg_state_t;

    brg_state_t s_d, s_q;
    logic       step;

    always_comb begin
        s_d        = s_q;
        step       = (s_q.mode == BRG_RUN) && tick_i && !start_i && !stop_i;
        roll_evt_o = step && !hold_i && (s_q.cnt == CNT_ZERO);
        if (start_i) begin
            s_d.mode = BRG_RUN;
            s_d.cnt  = reload_i;
        end else if (stop_i) begin
            s_d.mode = BRG_HALT;
            s_d.cnt  = CNT_ZERO;
        end else if (step) begin
            if (hold_i || (s_q.cnt == CNT_ZERO)) begin
                s_d.cnt = reload_i;
            end else begin
                s_d.cnt = s_q.cnt - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.mode <= BRG_HALT;
            s_q.cnt  <= CNT_ZERO;
        end else begin
            s_q <= s_d;
        end
    end

    assign running_o = (s_q.mode == BRG_RUN);

    AST_HALT_STAYS_STILL: assert property (@(posedge clk) disable iff (rst)
        (s_q.mode == BRG_HALT && !start_i) |=> (s_q.mode == BRG_HALT && $stable(s_q.cnt))); // R3

    AST_DECR_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (s_q.mode == BRG_RUN && tick_i && !hold_i && !start_i && !stop_i && s_q.cnt != CNT_ZERO)
        |=> (s_q.cnt == $past(s_q.cnt) - CNT_ONE)); // R4

    AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !start_i && !stop_i) |=> $stable(s_q.cnt)); // R4

    AST_RELOAD_AT_ROLL: assert property (@(posedge clk) disable iff (rst)
        roll_evt_o |=> (s_q.cnt == $past(reload_i) && s_q.mode == BRG_RUN)); // R5

    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s_q.mode == BRG_RUN && tick_i && hold_i && !start_i && !stop_i)
        |=> (s_q.cnt == $past(reload_i))); // R7

    AST_START_WINS: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (s_q.mode == BRG_RUN && s_q.cnt == $past(reload_i))); // R11

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !start_i) |=> (s_q.mode == BRG_HALT)); // R9

endmodule

// File: rtl/scl_level_gen.sv
module scl_level_gen
    import scl_div_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic roll_evt_i,
    output logic scl_o,
    output logic roll_o
);

    scl_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.roll = roll_evt_i;
        if (roll_evt_i) begin
            st_d.level = ~st_q.level;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.level <= SCL_RELEASED;
            st_q.roll  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_o  = st_q.level;
    assign roll_o = st_q.roll;

    AST_LEVEL_ONLY_ON_ROLL: assert property (@(posedge clk) disable iff (rst)
        !roll_evt_i |=> $stable(st_q.level)); // R9

    AST_ROLL_MARKS_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        st_q.roll |-> (st_q.level != $past(st_q.level))); // R8

    AST_RESET_RELEASED: assert property (@(posedge clk)
        rst |=> (st_q.level == SCL_RELEASED && !st_q.roll)); // R10

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_div_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic             buf_wr_i,
    input  logic             seq_done_i,
    input  logic             scl_in_i,
    output logic             scl_drive_o,
    output logic             roll_o
);

    localparam int SPARE_W = DIV_W - CNT_W;

    logic [CNT_W-1:0] reload;
    logic             hold;
    logic             roll_evt;
    logic             running;
    logic             unused_running;

    assign reload = divisor_i[CNT_W-1:0];

    generate
        if (SPARE_W > 0) begin : g_spare
            logic unused_div_hi;
            assign unused_div_hi = ^divisor_i[DIV_W-1:CNT_W];
        end
    endgenerate

    scl_stretch_detect i_stretch (
        .scl_drive_i (scl_drive_o),
        .scl_in_i    (scl_in_i),
        .hold_o      (hold)
    );

    scl_brg_counter #(
        .CNT_W (CNT_W)
    ) i_counter (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .reload_i   (reload),
        .start_i    (buf_wr_i),
        .stop_i     (seq_done_i),
        .hold_i     (hold),
        .roll_evt_o (roll_evt),
        .running_o  (running)
    );

    scl_level_gen i_level (
        .clk        (clk),
        .rst        (rst),
        .roll_evt_i (roll_evt),
        .scl_o      (scl_drive_o),
        .roll_o     (roll_o)
    );

    assign unused_running = running;

    AST_IDLE_NO_ROLL: assert property (@(posedge clk) disable iff (rst)
        (!running && !buf_wr_i) |=> !roll_o); // R3

endmodule

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic [7:0] divisor;
    logic       buf_wr;
    logic       seq_done;
    logic       force_low;
    logic       scl_in;
    logic       scl_drv;
    logic       roll;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    assign scl_in = scl_drv & ~force_low;

    scl_rate_gen i_scl_rate_gen (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .divisor_i   (divisor),
        .buf_wr_i    (buf_wr),
        .seq_done_i  (seq_done),
        .scl_in_i    (scl_in),
        .scl_drive_o (scl_drv),
        .roll_o      (roll)
    );

    // Each entry: {divisor, tick spacing in cycles}
    localparam logic [15:0] VEC [8] = '{
        {8'h18, 8'd1}, {8'h09, 8'd2}, {8'h00, 8'd1}, {8'h00, 8'd2},
        {8'h03, 8'd3}, {8'h83, 8'd1}, {8'hFF, 8'd1}, {8'h7F, 8'd2}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick = 1'b0; buf_wr = 1'b0; seq_done = 1'b0; force_low = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic start_xfer();
        buf_wr = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0;
    endtask

    // Runs ticks every 'div' cycles until SCL changes; cycles counted from the last event edge.
    task automatic run_half(input int div, output int cyc, output int rolls);
        logic prev;
        prev  = scl_drv;
        cyc   = 0;
        rolls = 0;
        do begin
            tick = (((cyc + 1) % div) == 0);
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (roll) rolls++;
        end while (scl_drv == prev && cyc < 2000);
        tick = 1'b0;
    endtask

    task automatic hold_check(input int n, input int div, output int changes, output int rolls);
        logic prev;
        changes = 0;
        rolls   = 0;
        for (int i = 1; i <= n; i++) begin
            prev = scl_drv;
            tick = ((i % div) == 0);
            @(posedge clk);
            @(negedge clk);
            if (scl_drv != prev) changes++;
            if (roll) rolls++;
        end
        tick = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cyc, rolls, chg, exp_half, div;
        rst = 1'b1; tick = 1'b0; divisor = 8'h00; buf_wr = 1'b0; seq_done = 1'b0; force_low = 1'b0;

        // R10: reset state
        do_reset();
        check(scl_drv == 1'b1, "R10 scl after reset", scl_drv, 1);
        check(roll == 1'b0, "R10 roll after reset", roll, 0);

        // R3: ticks while stopped do nothing
        divisor = 8'h02;
        hold_check(40, 1, chg, rolls);
        check(chg == 0, "R3 idle scl changes", chg, 0);
        check(rolls == 0, "R3 idle rolls", rolls, 0);

        // R1 R2 R4 R5 R6 R8: vector table
        foreach (VEC[k]) begin
            do_reset();
            divisor  = VEC[k][15:8];
            div      = int'(VEC[k][7:0]);
            exp_half = (int'(VEC[k][14:8]) + 1) * div;
            start_xfer();
            run_half(div, cyc, rolls);
            check(cyc == exp_half, "R4 R1 R6 first half length", cyc, exp_half);
            check(scl_drv == 1'b0, "R2 first edge goes low", scl_drv, 0);
            check(rolls == 1, "R8 one roll per half", rolls, 1);
            run_half(div, cyc, rolls);
            check(cyc == exp_half, "R5 second half length", cyc, exp_half);
            check(scl_drv == 1'b1, "R5 second edge goes high", scl_drv, 1);
            check(rolls == 1, "R8 one roll second half", rolls, 1);
        end

        // R5: divisor change in mid half period takes effect at the next reload
        do_reset();
        divisor = 8'h02;
        start_xfer();
        divisor = 8'h05;
        run_half(1, cyc, rolls);
        check(cyc == 3, "R5 current half keeps old reload", cyc, 3);
        run_half(1, cyc, rolls);
        check(cyc == 6, "R5 next half uses new reload", cyc, 6);

        // R9: stop with SCL low, level frozen, then restart
        do_reset();
        divisor = 8'h03;
        start_xfer();
        run_half(1, cyc, rolls);
        seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
        hold_check(30, 1, chg, rolls);
        check(chg == 0 && scl_drv == 1'b0, "R9 frozen low", scl_drv, 0);
        check(rolls == 0, "R9 no rolls after stop", rolls, 0);
        start_xfer();
        run_half(1, cyc, rolls);
        check(cyc == 4 && scl_drv == 1'b1, "R9 restart from frozen level", cyc, 4);

        // R9: stop with SCL high
        run_half(1, cyc, rolls);
        run_half(1, cyc, rolls);
        seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
        hold_check(30, 1, chg, rolls);
        check(chg == 0 && scl_drv == 1'b1, "R9 frozen high", chg, 0);

        // R7: clock stretch holds the high phase
        do_reset();
        divisor = 8'h04;
        start_xfer();
        run_half(1, cyc, rolls);
        force_low = 1'b1;
        run_half(1, cyc, rolls);
        check(cyc == 5 && scl_drv == 1'b1, "R7 release after low half", cyc, 5);
        hold_check(20, 1, chg, rolls);
        check(chg == 0 && rolls == 0, "R7 no change while stretched", chg, 0);
        force_low = 1'b0;
        run_half(1, cyc, rolls);
        check(cyc == 5, "R7 full high phase after stretch", cyc, 5);
        check(scl_drv == 1'b0, "R7 low after stretched high", scl_drv, 0);

        // R11: start and stop on the same edge
        do_reset();
        divisor = 8'h03;
        start_xfer();
        run_half(1, cyc, rolls);
        buf_wr = 1'b1; seq_done = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0; seq_done = 1'b0;
        run_half(1, cyc, rolls);
        check(cyc == 4 && scl_drv == 1'b1, "R11 start wins over stop", cyc, 4);

        // R10: reset in mid transfer
        do_reset();
        divisor = 8'h02;
        start_xfer();
        run_half(1, cyc, rolls);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(scl_drv == 1'b1 && roll == 1'b0, "R10 reset mid transfer", scl_drv, 1);
        hold_check(20, 1, chg, rolls);
        check(chg == 0 && rolls == 0, "R10 counter stopped by reset", chg, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule